// File: doc/BRIEF.md
# Accumulator Register-Reference Unit

This block holds the working state of a small accumulator machine: a 16-bit accumulator, a one-bit extend flag that catches carries and circulated bits, and a run flag that a halt operation clears. When the sequencer strobes a register-reference instruction, the twelve low instruction bits each name one operation. These operations are clearing, complementing, incrementing and circulating the accumulator through the extend flag, four skip tests, and halt. The block carries out one of them in that cycle.

The same accumulator also takes the results of memory-operand instructions. These are a bitwise AND with a data word, an add with the carry kept in the extend flag, a straight transfer of the data word, and a load of the low byte from an 8-bit input register. A small select code chooses among them. The skip request is a combinational output, so the sequencer can advance its program counter by one in the same cycle as the strobe.

Top module: `accRegUnit`

## Requirements
- R1: After reset the accumulator is 0, the extend flag is 0, the run flag is 1, and skipReq is 0.
- R2: With rrStrobe high, the single selected operation takes effect at the next clock edge: bit 11 clears the accumulator, bit 10 clears the extend flag, bit 9 inverts the accumulator, and bit 8 inverts the extend flag.
- R3: Bit 7 circulates right: the accumulator shifts right, the old extend flag enters bit 15, and the old bit 0 goes to the extend flag. Bit 6 circulates left: the accumulator shifts left, the old extend flag enters bit 0, and the old bit 15 goes to the extend flag.
- R4: Bit 5 adds 1 to the accumulator modulo 2^16 and leaves the extend flag unchanged, so 0xFFFF becomes 0x0000.
- R5: In the strobe cycle, skipReq is high when the selected bit and its test match the current values. Bit 4 tests accumulator bit 15 == 0, bit 3 tests accumulator bit 15 == 1, bit 2 tests accumulator == 0, and bit 1 tests extend flag == 0. A skip operation changes no register.
- R6: Bit 0 clears the run flag. Nothing else sets it again except reset.
- R7: When several instruction bits are set, only the lowest-numbered set bit takes effect. When all bits are 0, the strobe changes nothing and skipReq stays 0.
- R8: With rrStrobe low, loadSel selects the accumulator load. Code 1 loads acc AND data. Code 2 loads acc + data and puts the carry out into the extend flag. Code 3 loads the data word. Code 4 loads the input byte into bits 7..0 and keeps bits 15..8. Codes 0, 5, 6 and 7 change nothing.
- R9: While rrStrobe is high, loadSel is ignored. While rrStrobe is low, the instruction bits are ignored and skipReq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rrStrobe | input | 1 | Execute a register-reference instruction this cycle |
| irLow | input | 12 | Instruction bits 11..0, one bit per operation |
| drIn | input | 16 | Data word from the operand register |
| inByte | input | 8 | Input register byte |
| loadSel | input | 3 | Accumulator load select code (R8) |
| acOut | output | 16 | Accumulator |
| eOut | output | 1 | Extend flag |
| sOut | output | 1 | Run flag |
| skipReq | output | 1 | Skip the next instruction (combinational) |

## Verification
Single-bit instruction words are tried on each operation, with accumulator values chosen on the sign and zero boundaries. These separate the four skip tests from one another and also test a skip that must not fire. Words with several bits set show whether the lowest bit wins over higher ones. Random accumulator and data values through the add path tell the carry apart from the sum. Words that mix the strobe with a load select, and unused select codes, show whether anything leaks into the accumulator when it should hold.

// File: rtl/accPkg.sv
package accPkg;
  localparam int DATA_W = 16;
  localparam int IN_W   = 8;
  localparam int IR_W   = 12;

  typedef enum logic [2:0] {
    LD_NONE = 3'd0,
    LD_AND  = 3'd1,
    LD_ADD  = 3'd2,
    LD_XFER = 3'd3,
    LD_BYTE = 3'd4
  } loadSel_e;

  // strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic acClr;
    logic eClr;
    logic acCmp;
    logic eCmp;
    logic acShr;
    logic acShl;
    logic acInc;
    logic sClr;
    logic acAnd;
    logic acAdd;
    logic acXfer;
    logic acByte;
  } accStrobes_t;
endpackage

// File: rtl/accCtrl.sv
module accCtrl
  import accPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rrStrobe,
  input  logic [IW-1:0] irLow,
  input  logic [2:0]    loadSel,
  input  logic [DW-1:0] acCur,
  input  logic          eCur,
  output accStrobes_t   strobes,
  output logic          skipReq
);
  // operation bit positions inside the instruction word
  localparam int B_HLT = 0;
  localparam int B_SZE = 1;
  localparam int B_SZA = 2;
  localparam int B_SNA = 3;
  localparam int B_SPA = 4;
  localparam int B_INC = 5;
  localparam int B_CIL = 6;
  localparam int B_CIR = 7;
  localparam int B_CME = 8;
  localparam int B_CMA = 9;
  localparam int B_CLE = 10;
  localparam int B_CLA = 11;

  logic [IW-1:0] pick;
  logic          acZero;

  // isolate the lowest set bit: fixed priority, low number wins
  assign pick   = rrStrobe ? (irLow & (~irLow + 1'b1)) : '0;
  assign acZero = (acCur == '0);

  always_comb begin
    strobes        = '0;
    strobes.acClr  = pick[B_CLA];
    strobes.eClr   = pick[B_CLE];
    strobes.acCmp  = pick[B_CMA];
    strobes.eCmp   = pick[B_CME];
    strobes.acShr  = pick[B_CIR];
    strobes.acShl  = pick[B_CIL];
    strobes.acInc  = pick[B_INC];
    strobes.sClr   = pick[B_HLT];
    if (!rrStrobe) begin
      strobes.acAnd  = (loadSel == LD_AND);
      strobes.acAdd  = (loadSel == LD_ADD);
      strobes.acXfer = (loadSel == LD_XFER);
      strobes.acByte = (loadSel == LD_BYTE);
    end
  end

  assign skipReq = (pick[B_SPA] & ~acCur[DW-1])
                 | (pick[B_SNA] &  acCur[DW-1])
                 | (pick[B_SZA] &  acZero)
                 | (pick[B_SZE] & ~eCur);

  // R9: no skip without the register-reference strobe
  assert_skip_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rrStrobe |-> !skipReq);
  // R7: an all-zero instruction word never requests a skip
  assert_empty_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irLow == '0) |-> !skipReq);
endmodule

// File: rtl/accData.sv
module accData
  import accPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = IN_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  accStrobes_t   strobes,
  input  logic [DW-1:0] drIn,
  input  logic [BW-1:0] inByte,
  output logic [DW-1:0] acReg,
  output logic          eReg,
  output logic          sReg
);
  logic [DW:0] sumWide;
  assign sumWide = {1'b0, acReg} + {1'b0, drIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acReg <= '0;
      eReg  <= 1'b0;
      sReg  <= 1'b1;
    end else begin
      if (strobes.acClr)       acReg <= '0;
      else if (strobes.acCmp)  acReg <= ~acReg;
      else if (strobes.acShr)  begin acReg <= {eReg, acReg[DW-1:1]}; eReg <= acReg[0]; end
      else if (strobes.acShl)  begin acReg <= {acReg[DW-2:0], eReg}; eReg <= acReg[DW-1]; end
      else if (strobes.acInc)  acReg <= acReg + 1'b1;
      else if (strobes.acAnd)  acReg <= acReg & drIn;
      else if (strobes.acAdd)  begin acReg <= sumWide[DW-1:0]; eReg <= sumWide[DW]; end
      else if (strobes.acXfer) acReg <= drIn;
      else if (strobes.acByte) acReg[BW-1:0] <= inByte;
      if (strobes.eClr) eReg <= 1'b0;
      if (strobes.eCmp) eReg <= ~eReg;
      if (strobes.sClr) sReg <= 1'b0;
    end
  end

  // R7: control presents at most one strobe per cycle
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  // R2
  assert_ac_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acClr |=> (acReg == '0));
  assert_ac_invert_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acCmp |=> (acReg == ~$past(acReg)));
  // R3
  assert_circ_right_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acShr |=> (acReg == {$past(eReg), $past(acReg[DW-1:1])}) && (eReg == $past(acReg[0])));
  assert_circ_left_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acShl |=> (acReg == {$past(acReg[DW-2:0]), $past(eReg)}) && (eReg == $past(acReg[DW-1])));
  // R4
  assert_incr_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acInc |=> (acReg == $past(acReg) + 1'b1) && $stable(eReg));
  // R6: run flag never rises outside reset
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sReg |=> !sReg);
  // R8: add keeps carry in the extend flag
  assert_add_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acAdd |=> ({eReg, acReg} == {1'b0, $past(acReg)} + {1'b0, $past(drIn)}));
  // R8/R9: no strobe, no change
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> $stable(acReg) && $stable(eReg) && $stable(sReg));
endmodule

// File: rtl/accRegUnit.sv
module accRegUnit
  import accPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int BW = IN_W,
  parameter int IW = IR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rrStrobe,
  input  logic [IW-1:0] irLow,
  input  logic [DW-1:0] drIn,
  input  logic [BW-1:0] inByte,
  input  logic [2:0]    loadSel,
  output logic [DW-1:0] acOut,
  output logic          eOut,
  output logic          sOut,
  output logic          skipReq
);
  accStrobes_t strobes;

  accCtrl #(.DW(DW), .IW(IW)) uCtrl (
    .clk(clk), .rstN(rstN), .rrStrobe(rrStrobe), .irLow(irLow),
    .loadSel(loadSel), .acCur(acOut), .eCur(eOut),
    .strobes(strobes), .skipReq(skipReq)
  );

  accData #(.DW(DW), .BW(BW)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .drIn(drIn), .inByte(inByte),
    .acReg(acOut), .eReg(eOut), .sReg(sOut)
  );
endmodule

// File: tb/tb_accRegUnit.sv
`timescale 1ns/1ps
module tb_accRegUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rrStrobe = 1'b0;
  logic [11:0] irLow = '0;
  logic [15:0] drIn = '0;
  logic [7:0]  inByte = '0;
  logic [2:0]  loadSel = '0;
  logic [15:0] acOut;
  logic        eOut, sOut, skipReq;

  int total = 0;
  int bad = 0;
  logic [15:0] mAc;
  logic        mE, mS;

  always #4 clk = ~clk;

  accRegUnit dut (.*);

  function automatic int lowIdx(input logic [11:0] ir);
    for (int i = 0; i < 12; i++) if (ir[i]) return i;
    return -1;
  endfunction

  function automatic string tagOf(input logic st, input logic [11:0] ir, input logic [2:0] sel);
    int k;
    if (!st) return "R8";
    k = lowIdx(ir);
    if (k < 0) return "R7";
    if (k >= 8) return "R2";
    if (k >= 6) return "R3";
    if (k == 5) return "R4";
    if (k >= 1) return "R5";
    return "R6";
  endfunction

  function automatic logic refSkip(input logic st, input logic [11:0] ir, input logic [15:0] ac, input logic e);
    int k;
    if (!st) return 1'b0;
    k = lowIdx(ir);
    case (k)
      4: return !ac[15];
      3: return ac[15];
      2: return ac == 16'h0;
      1: return !e;
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelStep(input logic st, input logic [11:0] ir, input logic [15:0] dr,
                           input logic [7:0] ib, input logic [2:0] sel);
    logic [16:0] w;
    logic [15:0] a;
    logic        e;
    a = mAc; e = mE;
    if (st) begin
      case (lowIdx(ir))
        11: mAc = 16'h0;
        10: mE = 1'b0;
        9:  mAc = ~a;
        8:  mE = ~e;
        7:  begin mAc = {e, a[15:1]}; mE = a[0]; end
        6:  begin mAc = {a[14:0], e}; mE = a[15]; end
        5:  mAc = a + 16'h1;
        0:  mS = 1'b0;
        default: ;
      endcase
    end else begin
      case (sel)
        3'd1: mAc = a & dr;
        3'd2: begin w = {1'b0, a} + {1'b0, dr}; mAc = w[15:0]; mE = w[16]; end
        3'd3: mAc = dr;
        3'd4: mAc = {a[15:8], ib};
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called just after a negedge; checks skip in the cycle, state after the edge
  task automatic step(input string tag, input logic st, input logic [11:0] ir,
                      input logic [15:0] dr, input logic [7:0] ib, input logic [2:0] sel);
    logic expSkip;
    rrStrobe = st; irLow = ir; drIn = dr; inByte = ib; loadSel = sel;
    #1;
    expSkip = refSkip(st, ir, mAc, mE);
    chk(tag, "skipReq", {15'h0, skipReq}, {15'h0, expSkip});
    @(posedge clk);
    modelStep(st, ir, dr, ib, sel);
    @(negedge clk);
    chk(tag, "acc", acOut, mAc);
    chk(tag, "extend", {15'h0, eOut}, {15'h0, mE});
    chk(tag, "run", {15'h0, sOut}, {15'h0, mS});
    rrStrobe = 1'b0; loadSel = 3'd0; irLow = '0;
  endtask

  task automatic loadAc(input logic [15:0] v);
    step("R8", 1'b0, 12'h0, v, 8'h0, 3'd3);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [11:0] ir;
    logic        st;
    logic [2:0]  sel;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    mAc = 16'h0; mE = 1'b0; mS = 1'b1;
    // R1 reset state
    chk("R1", "acc", acOut, 16'h0);
    chk("R1", "extend", {15'h0, eOut}, 16'h0);
    chk("R1", "run", {15'h0, sOut}, 16'h1);
    chk("R1", "skipReq", {15'h0, skipReq}, 16'h0);
    @(negedge clk);

    // R5 zero tests on a cleared accumulator
    step("R5", 1'b1, 12'h004, 16'h0, 8'h0, 3'd0);
    step("R5", 1'b1, 12'h002, 16'h0, 8'h0, 3'd0);
    step("R5", 1'b1, 12'h008, 16'h0, 8'h0, 3'd0);
    step("R5", 1'b1, 12'h010, 16'h0, 8'h0, 3'd0);
    // R4 increment wrap
    loadAc(16'hFFFF);
    step("R5", 1'b1, 12'h008, 16'h0, 8'h0, 3'd0);
    step("R4", 1'b1, 12'h020, 16'h0, 8'h0, 3'd0);
    // R2 extend invert, then circulates with extend = 1
    step("R2", 1'b1, 12'h100, 16'h0, 8'h0, 3'd0);
    step("R5", 1'b1, 12'h002, 16'h0, 8'h0, 3'd0);
    loadAc(16'h8001);
    step("R3", 1'b1, 12'h080, 16'h0, 8'h0, 3'd0);
    step("R3", 1'b1, 12'h040, 16'h0, 8'h0, 3'd0);
    step("R3", 1'b1, 12'h040, 16'h0, 8'h0, 3'd0);
    // R2 invert, clears
    step("R2", 1'b1, 12'h200, 16'h0, 8'h0, 3'd0);
    step("R2", 1'b1, 12'h400, 16'h0, 8'h0, 3'd0);
    step("R2", 1'b1, 12'h800, 16'h0, 8'h0, 3'd0);
    // R8 add with carry, AND, input byte
    loadAc(16'hC000);
    step("R8", 1'b0, 12'h0, 16'h5001, 8'h0, 3'd2);
    step("R8", 1'b0, 12'h0, 16'h0FF0, 8'h0, 3'd1);
    loadAc(16'hA5A5);
    step("R8", 1'b0, 12'h0, 16'h0, 8'h3C, 3'd4);
    step("R8", 1'b0, 12'hFFF, 16'h1234, 8'h0, 3'd5);
    step("R8", 1'b0, 12'h0, 16'h1234, 8'h0, 3'd7);
    // R9 strobe with a load select; instruction bits without strobe
    step("R9", 1'b1, 12'h004, 16'h1234, 8'h0, 3'd3);
    step("R9", 1'b0, 12'h800, 16'h0, 8'h0, 3'd0);
    // R7 lowest bit wins; empty word
    step("R7", 1'b1, 12'h8C0, 16'h0, 8'h0, 3'd0);
    step("R7", 1'b1, 12'h820, 16'h0, 8'h0, 3'd0);
    step("R7", 1'b1, 12'h000, 16'h0, 8'h0, 3'd0);
    step("R7", 1'b1, 12'hA14, 16'h0, 8'h0, 3'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      st = $urandom_range(0, 1);
      if ($urandom_range(0, 2) == 0) ir = 12'($urandom);
      else ir = 12'h1 << $urandom_range(0, 11);
      if ($urandom_range(0, 40) != 0) ir[0] = 1'b0;
      sel = 3'($urandom_range(0, 7));
      step(tagOf(st, ir, sel), st, ir, 16'($urandom), 8'($urandom), sel);
    end

    // R6 halt, then nothing restores the run flag
    step("R6", 1'b1, 12'h001, 16'h0, 8'h0, 3'd0);
    step("R6", 1'b1, 12'h020, 16'h0, 8'h0, 3'd0);
    step("R6", 1'b0, 12'h0, 16'hFFFF, 8'h0, 3'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule